// File: doc/BRIEF.md
# Configurable product-term logic macrocell

This block models one cell of a programmable logic array whose function is chosen at run time through static configuration ports. Five product terms are formed as AND functions over selectable true or complemented bits of an array-input vector. Any of them can be added into a local OR sum, and every one of them is also available to the control uses of the cell: the second XOR operand, the register clock, the clock enable, asynchronous reset, asynchronous preset, separate register data, the second register operand, the output enable and the foldback term.

The sum is widened by a cascade input from the neighbouring cell and passed on as a cascade output, so cells can be chained into wide sums. A storage element acts as a D, T, JK or SR flip-flop or as a level-sensitive latch. The pin output and the buried feedback each select the registered or the combinational value independently. All global clocks and product-term clocks are treated as data sampled on the system clock `clk`. A rising edge is a sampled low-to-high change of the chosen clock source.

Top module: `pterm_macrocell`

## Requirements
- R1: Product term i is the AND of `arr_in[j]` over every j with `cfg_mask_true[i][j]`=1 and of `~arr_in[j]` over every j with `cfg_mask_comp[i][j]`=1. A term with no mask bit set is 1. A control use whose selector `cfg_sel[u]` is 5, 6 or 7 sees 0. Use slots: 0 XOR, 1 clock, 2 clock enable, 3 reset, 4 preset, 5 data, 6 second operand (K/R), 7 output enable, 8 foldback.
- R2: The sum is the OR of `casc_in` and every term i with `cfg_to_sum[i]`=1. `casc_out` equals the sum combinationally.
- R3: The combinational value is the sum XOR a second operand. `cfg_xor_src` 0 selects constant 0, 1 selects constant 1, and 2 selects the term in slot 0.
- R4: Register data is the XOR value when `cfg_data_src`=0, the slot-5 term when it is 1, and `pin_in` when it is 2.
- R5: `cfg_mode` 0 (D) loads the data and 1 (T) inverts the state when the data is 1. The load happens at the first `clk` edge at which the chosen clock is seen high after being seen low.
- R6: `cfg_mode` 2 (JK) uses J = data and K = slot-6 term. 10 sets, 01 clears, 11 toggles and 00 holds.
- R7: `cfg_mode` 3 (SR) uses S = data and R = slot-6 term. 10 sets, 01 clears, and both 00 and 11 hold.
- R8: `cfg_mode` 4 (latch) loads the data at every `clk` edge at which the chosen clock is high, and holds while it is low.
- R9: `cfg_clk_src` 0..2 selects `gclk[0..2]` and 3 selects the slot-1 term. With a global clock and `cfg_ce_en`=1, a low slot-2 term causes edges to be ignored.
- R10: Reset is selected by `cfg_ar_src`: 0 off, 1 `gclr`, 2 slot-3 term, 3 `gclr` OR that term. Preset is the slot-4 term when `cfg_ap_en`=1. Both force the stored value at once, without waiting for a clock, and reset wins over preset.
- R11: `pin_out` is the stored value when `cfg_out_reg`=1 and the combinational value otherwise. `fb_out` makes the same choice independently through `cfg_fb_reg`.
- R12: `pin_oe` follows `cfg_oe_src` as follows: 0 `goe[0]`, 1 `~goe[0]`, 2 `goe[1]`, 3 `~goe[1]`, 4..7 the slot-7 term.
- R13: `fold_out` is the inverse of the slot-8 term.
- R14: While `rst_n` is low the stored value is 0. A chosen clock that is already high when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all clock sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_in | input | N_IN | Array inputs (global and regional bus) |
| casc_in | input | 1 | Sum arriving from the neighbouring cell |
| gclk | input | 3 | Global clock levels |
| gclr | input | 1 | Global clear |
| goe | input | 2 | Global output-enable signals |
| pin_in | input | 1 | Value seen at the pin |
| cfg_mask_true | input | 5 x N_IN | True-input masks per term |
| cfg_mask_comp | input | 5 x N_IN | Complement-input masks per term |
| cfg_to_sum | input | 5 | Terms that enter the OR sum |
| cfg_sel | input | 9 x 3 | Term index for each control use slot |
| cfg_xor_src | input | 2 | Second XOR operand source |
| cfg_data_src | input | 2 | Register data source |
| cfg_mode | input | 3 | Storage behaviour |
| cfg_clk_src | input | 2 | Clock source |
| cfg_ce_en | input | 1 | Enables the clock-enable term |
| cfg_ar_src | input | 2 | Reset source |
| cfg_ap_en | input | 1 | Enables the preset term |
| cfg_oe_src | input | 3 | Output-enable source |
| cfg_out_reg | input | 1 | Pin output takes the stored value |
| cfg_fb_reg | input | 1 | Feedback takes the stored value |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |
| fb_out | output | 1 | Buried feedback |
| casc_out | output | 1 | Sum passed to the next cell |
| fold_out | output | 1 | Inverted foldback term |

## Verification
The assertions check the storage rules on every cycle: reset priority over preset, preset loading, JK toggling with both operands high, SR holding with both operands high, the latch holding while its clock is low, and the stored value staying put while the clock enable is low. They also check that an asserted cascade input always reaches the cascade output. Other behaviour is shown only by the bench scenarios. This covers the exact product-term and sum values, the source selections for data, clock, output enable and foldback, the timing of edge detection after reset release, and the fact that reset and preset act without a clock edge. The bench compares every output against its own model across random configurations and in the directed cases.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int N_PT   = 5;
  localparam int PT_W   = 3;
  localparam int PT_PAD = 2 ** PT_W;
  localparam int N_USE  = 9;

  // control use slots
  localparam int U_XOR  = 0;
  localparam int U_CLK  = 1;
  localparam int U_CE   = 2;
  localparam int U_AR   = 3;
  localparam int U_AP   = 4;
  localparam int U_D    = 5;
  localparam int U_K    = 6;
  localparam int U_OE   = 7;
  localparam int U_FOLD = 8;

  typedef enum logic [2:0] {
    RM_D = 3'd0, RM_T = 3'd1, RM_JK = 3'd2, RM_SR = 3'd3, RM_LATCH = 3'd4
  } reg_mode_e;
endpackage

// File: rtl/mc_and_array.sv
module mc_and_array import mc_pkg::*; #(
  parameter int N_IN = 8
) (
  input  logic [N_IN-1:0]            arr_i,
  input  logic [N_PT-1:0][N_IN-1:0]  mask_t_i,
  input  logic [N_PT-1:0][N_IN-1:0]  mask_c_i,
  output logic [N_PT-1:0]            pt_o
);
  for (genvar g = 0; g < N_PT; g++) begin : g_term
    assign pt_o[g] = &((~mask_t_i[g] | arr_i) & (~mask_c_i[g] | ~arr_i));
  end
endmodule

// File: rtl/mc_logic.sv
module mc_logic import mc_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_PT-1:0] pt_i,
  input  logic [N_PT-1:0] to_sum_i,
  input  logic            casc_i,
  input  logic            xor_pt_i,
  input  logic [1:0]      xor_src_i,
  input  logic            q_i,
  input  logic            out_reg_i,
  input  logic            fb_reg_i,
  input  logic [1:0]      goe_i,
  input  logic [2:0]      oe_src_i,
  input  logic            oe_pt_i,
  input  logic            fold_pt_i,
  output logic            xor_o,
  output logic            casc_o,
  output logic            pin_o,
  output logic            oe_o,
  output logic            fb_o,
  output logic            fold_o
);
  logic sum;
  logic xor_b;

  always_comb begin
    sum = casc_i | (|(pt_i & to_sum_i));
    unique case (xor_src_i)
      2'd1:    xor_b = 1'b1;
      2'd2:    xor_b = xor_pt_i;
      default: xor_b = 1'b0;
    endcase
    xor_o = sum ^ xor_b;
    case (oe_src_i)
      3'd0:    oe_o = goe_i[0];
      3'd1:    oe_o = ~goe_i[0];
      3'd2:    oe_o = goe_i[1];
      3'd3:    oe_o = ~goe_i[1];
      default: oe_o = oe_pt_i;
    endcase
  end

  assign casc_o = sum;
  assign pin_o  = out_reg_i ? q_i : xor_o;
  assign fb_o   = fb_reg_i  ? q_i : xor_o;
  assign fold_o = ~fold_pt_i;

  // R2
  casc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    casc_i |-> casc_o);
endmodule

// File: rtl/mc_storage.sv
module mc_storage import mc_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  reg_mode_e mode_i,
  input  logic [1:0] clk_src_i,
  input  logic      ce_en_i,
  input  logic [1:0] ar_src_i,
  input  logic      ap_en_i,
  input  logic [2:0] gclk_i,
  input  logic      gclr_i,
  input  logic      clk_pt_i,
  input  logic      ce_pt_i,
  input  logic      ar_pt_i,
  input  logic      ap_pt_i,
  input  logic      d_i,
  input  logic      k_i,
  output logic      q_o
);
  logic q_reg, q_next;
  logic lvl_prev;
  logic lvl, ce_ok, fire, load, ar, ap, nxt;

  always_comb begin
    case (clk_src_i)
      2'd0:    lvl = gclk_i[0];
      2'd1:    lvl = gclk_i[1];
      2'd2:    lvl = gclk_i[2];
      default: lvl = clk_pt_i;
    endcase
    ce_ok = (clk_src_i == 2'd3) || !ce_en_i || ce_pt_i;
    case (ar_src_i)
      2'd1:    ar = gclr_i;
      2'd2:    ar = ar_pt_i;
      2'd3:    ar = gclr_i | ar_pt_i;
      default: ar = 1'b0;
    endcase
    ap   = ap_en_i & ap_pt_i;
    fire = lvl & ~lvl_prev & ce_ok;
    case (mode_i)
      RM_T:    nxt = q_reg ^ d_i;
      RM_JK:   nxt = (d_i & ~q_reg) | (~k_i & q_reg);
      RM_SR:   nxt = (d_i & ~k_i) | (q_reg & ~(k_i & ~d_i));
      default: nxt = d_i;
    endcase
    load = (mode_i == RM_LATCH) ? lvl : fire;
    if (ar)        q_next = 1'b0;
    else if (ap)   q_next = 1'b1;
    else if (load) q_next = nxt;
    else           q_next = q_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_reg    <= 1'b0;
      lvl_prev <= 1'b1;
    end else begin
      q_reg    <= q_next;
      lvl_prev <= lvl;
    end
  end

  assign q_o = ar ? 1'b0 : (ap ? 1'b1 : q_reg);

  // R10
  reset_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ar |=> (q_reg == 1'b0));
  // R10
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap && !ar) |=> (q_reg == 1'b1));
  // R6
  jk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == RM_JK && fire && d_i && k_i && !ar && !ap) |=> (q_reg != $past(q_reg)));
  // R7
  sr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == RM_SR && d_i && k_i && !ar && !ap) |=> $stable(q_reg));
  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == RM_LATCH && !lvl && !ar && !ap) |=> $stable(q_reg));
  // R9
  ce_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != RM_LATCH && clk_src_i != 2'd3 && ce_en_i && !ce_pt_i && !ar && !ap)
    |=> $stable(q_reg));
endmodule

// File: rtl/pterm_macrocell.sv
module pterm_macrocell import mc_pkg::*; #(
  parameter int N_IN = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_IN-1:0]                arr_in,
  input  logic                           casc_in,
  input  logic [2:0]                     gclk,
  input  logic                           gclr,
  input  logic [1:0]                     goe,
  input  logic                           pin_in,
  input  logic [N_PT-1:0][N_IN-1:0]      cfg_mask_true,
  input  logic [N_PT-1:0][N_IN-1:0]      cfg_mask_comp,
  input  logic [N_PT-1:0]                cfg_to_sum,
  input  logic [N_USE-1:0][PT_W-1:0]     cfg_sel,
  input  logic [1:0]                     cfg_xor_src,
  input  logic [1:0]                     cfg_data_src,
  input  logic [2:0]                     cfg_mode,
  input  logic [1:0]                     cfg_clk_src,
  input  logic                           cfg_ce_en,
  input  logic [1:0]                     cfg_ar_src,
  input  logic                           cfg_ap_en,
  input  logic [2:0]                     cfg_oe_src,
  input  logic                           cfg_out_reg,
  input  logic                           cfg_fb_reg,
  output logic                           pin_out,
  output logic                           pin_oe,
  output logic                           fb_out,
  output logic                           casc_out,
  output logic                           fold_out
);
  logic [N_PT-1:0]   pt;
  logic [PT_PAD-1:0] pt_pad;
  logic [N_USE-1:0]  use_pt;
  logic              xor_val, d_val, q_val;

  mc_and_array #(.N_IN(N_IN)) i_and (
    .arr_i(arr_in), .mask_t_i(cfg_mask_true), .mask_c_i(cfg_mask_comp), .pt_o(pt)
  );

  assign pt_pad = {{(PT_PAD-N_PT){1'b0}}, pt};

  for (genvar u = 0; u < N_USE; u++) begin : g_use
    assign use_pt[u] = pt_pad[cfg_sel[u]];
  end

  always_comb begin
    case (cfg_data_src)
      2'd1:    d_val = use_pt[U_D];
      2'd2:    d_val = pin_in;
      default: d_val = xor_val;
    endcase
  end

  mc_storage i_store (
    .clk(clk), .rst_n(rst_n), .mode_i(reg_mode_e'(cfg_mode)),
    .clk_src_i(cfg_clk_src), .ce_en_i(cfg_ce_en), .ar_src_i(cfg_ar_src),
    .ap_en_i(cfg_ap_en), .gclk_i(gclk), .gclr_i(gclr),
    .clk_pt_i(use_pt[U_CLK]), .ce_pt_i(use_pt[U_CE]), .ar_pt_i(use_pt[U_AR]),
    .ap_pt_i(use_pt[U_AP]), .d_i(d_val), .k_i(use_pt[U_K]), .q_o(q_val)
  );

  mc_logic i_logic (
    .clk(clk), .rst_n(rst_n), .pt_i(pt), .to_sum_i(cfg_to_sum), .casc_i(casc_in),
    .xor_pt_i(use_pt[U_XOR]), .xor_src_i(cfg_xor_src), .q_i(q_val),
    .out_reg_i(cfg_out_reg), .fb_reg_i(cfg_fb_reg), .goe_i(goe),
    .oe_src_i(cfg_oe_src), .oe_pt_i(use_pt[U_OE]), .fold_pt_i(use_pt[U_FOLD]),
    .xor_o(xor_val), .casc_o(casc_out), .pin_o(pin_out), .oe_o(pin_oe),
    .fb_o(fb_out), .fold_o(fold_out)
  );
endmodule

// File: tb/test_pterm_macrocell.sv
module test_pterm_macrocell;
  import mc_pkg::*;
  localparam int NI = 8;

  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic rst_n;
  logic [NI-1:0] arr_in;
  logic casc_in, gclr, pin_in;
  logic [2:0] gclk;
  logic [1:0] goe;
  logic [N_PT-1:0][NI-1:0] mt, mc;
  logic [N_PT-1:0] route;
  logic [N_USE-1:0][PT_W-1:0] sel;
  logic [1:0] xsrc, dsrc, csrc, arsrc;
  logic [2:0] mode, oesrc;
  logic ceen, apen, oreg, freg;
  logic pin_out, pin_oe, fb_out, casc_out, fold_out;

  int total = 0;
  int bad = 0;
  logic m_q, m_prev;
  logic cur;

  pterm_macrocell #(.N_IN(NI)) i_pterm_macrocell (
    .clk(clk), .rst_n(rst_n), .arr_in(arr_in), .casc_in(casc_in), .gclk(gclk),
    .gclr(gclr), .goe(goe), .pin_in(pin_in), .cfg_mask_true(mt), .cfg_mask_comp(mc),
    .cfg_to_sum(route), .cfg_sel(sel), .cfg_xor_src(xsrc), .cfg_data_src(dsrc),
    .cfg_mode(mode), .cfg_clk_src(csrc), .cfg_ce_en(ceen), .cfg_ar_src(arsrc),
    .cfg_ap_en(apen), .cfg_oe_src(oesrc), .cfg_out_reg(oreg), .cfg_fb_reg(freg),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out), .casc_out(casc_out),
    .fold_out(fold_out)
  );

  function automatic logic m_term(int i);
    logic [NI-1:0] v;
    if (i >= N_PT) return 1'b0;
    v = (~mt[i] | arr_in) & (~mc[i] | ~arr_in);
    return &v;
  endfunction
  function automatic logic m_use(int u);
    return m_term(int'(sel[u]));
  endfunction
  function automatic logic m_sum();
    logic s = casc_in;
    for (int i = 0; i < N_PT; i++) if (route[i]) s |= m_term(i);
    return s;
  endfunction
  function automatic logic m_xor();
    logic x = 1'b0;
    if (xsrc == 2'd1) x = 1'b1;
    else if (xsrc == 2'd2) x = m_use(U_XOR);
    return m_sum() ^ x;
  endfunction
  function automatic logic m_data();
    if (dsrc == 2'd1) return m_use(U_D);
    if (dsrc == 2'd2) return pin_in;
    return m_xor();
  endfunction
  function automatic logic m_clk();
    if (csrc == 2'd3) return m_use(U_CLK);
    return gclk[csrc];
  endfunction
  function automatic logic m_ar();
    case (arsrc)
      2'd1: return gclr;
      2'd2: return m_use(U_AR);
      2'd3: return gclr | m_use(U_AR);
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic m_qeff();
    if (m_ar()) return 1'b0;
    if (apen && m_use(U_AP)) return 1'b1;
    return m_q;
  endfunction
  function automatic logic m_oe();
    case (oesrc)
      3'd0: return goe[0];
      3'd1: return ~goe[0];
      3'd2: return goe[1];
      3'd3: return ~goe[1];
      default: return m_use(U_OE);
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one system clock: model updates from the inputs present at the edge
  task automatic step();
    logic lvl, ce_ok, d, k;
    @(posedge clk);
    lvl = m_clk();
    ce_ok = (csrc == 2'd3) || !ceen || m_use(U_CE);
    d = m_data();
    k = m_use(U_K);
    if (m_ar()) m_q = 1'b0;
    else if (apen && m_use(U_AP)) m_q = 1'b1;
    else if (mode == 3'd4) begin
      if (lvl) m_q = d;
    end else if (lvl && !m_prev && ce_ok) begin
      case (mode)
        3'd1: m_q = m_q ^ d;
        3'd2: m_q = (d & ~m_q) | (~k & m_q);
        3'd3: m_q = (d & ~k) | (m_q & ~(k & ~d));
        default: m_q = d;
      endcase
    end
    m_prev = lvl;
    #1ns;
    check("R11 pin output", pin_out, oreg ? m_qeff() : m_xor());
    check("R11 feedback (R4 data path)", fb_out, freg ? m_qeff() : m_xor());
    check("R2 cascade", casc_out, m_sum());
    check("R13 foldback", fold_out, ~m_use(U_FOLD));
    check("R12 output enable", pin_oe, m_oe());
    @(negedge clk);
  endtask

  task automatic edge_pulse();
    gclk[0] = 1'b0; step();
    gclk[0] = 1'b1; step();
  endtask

  task automatic rand_cfg();
    for (int i = 0; i < N_PT; i++) begin
      mt[i] = NI'($urandom & $urandom & $urandom);
      mc[i] = NI'($urandom & $urandom & $urandom);
    end
    route = N_PT'($urandom);
    for (int u = 0; u < N_USE; u++) sel[u] = PT_W'($urandom % 6);
    xsrc  = 2'($urandom % 3);
    dsrc  = 2'($urandom % 3);
    mode  = 3'($urandom % 5);
    csrc  = 2'($urandom);
    ceen  = 1'($urandom);
    arsrc = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
    apen  = ($urandom % 3 == 0);
    oesrc = 3'($urandom % 6);
    oreg  = 1'($urandom);
    freg  = 1'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; arr_in = '0; casc_in = 0; gclk = '0; gclr = 0; goe = '0; pin_in = 0;
    mt = '0; mc = '0; route = '0; sel = '1; xsrc = 0; dsrc = 0; mode = 0; csrc = 0;
    ceen = 0; arsrc = 0; apen = 0; oesrc = 0; oreg = 1; freg = 1;
    m_q = 1'b0; m_prev = 1'b1;
    repeat (3) @(negedge clk);
    #1ns;
    check("R14 reset pin", pin_out, 1'b0);
    check("R14 reset feedback", fb_out, 1'b0);

    // clock already high at release: not an edge
    gclk = 3'b001; dsrc = 2'd2; pin_in = 1'b1;
    @(negedge clk); rst_n = 1'b1;
    step();
    check("R14 no edge at release", fb_out, 1'b0);
    edge_pulse();
    check("R5 D capture from pin (R4)", fb_out, 1'b1);
    mode = 3'd1;
    edge_pulse();
    check("R5 T toggle", fb_out, 1'b0);

    mode = 3'd2; sel[U_K] = 3'd0;
    for (int n = 0; n < 2; n++) begin
      cur = fb_out;
      edge_pulse();
      check("R6 JK toggle", fb_out, ~cur);
    end

    mode = 3'd3;
    cur = fb_out;
    edge_pulse();
    check("R7 SR both high holds", fb_out, cur);
    sel[U_K] = 3'd7;
    edge_pulse();
    check("R7 SR set", fb_out, 1'b1);

    mode = 3'd0; pin_in = 1'b0; ceen = 1'b1; sel[U_CE] = 3'd7;
    edge_pulse();
    check("R9 edge ignored with enable low", fb_out, 1'b1);
    sel[U_CE] = 3'd0;
    edge_pulse();
    check("R9 edge taken with enable high", fb_out, 1'b0);
    ceen = 1'b0;
    csrc = 2'd3; sel[U_CLK] = 3'd7; pin_in = 1'b1; step();
    sel[U_CLK] = 3'd0; step();
    check("R9 product-term clock", fb_out, 1'b1);
    csrc = 2'd0;

    mode = 3'd4; gclk[0] = 1'b1; pin_in = 1'b0; step();
    check("R8 latch transparent", fb_out, 1'b0);
    pin_in = 1'b1; step();
    check("R8 latch follows", fb_out, 1'b1);
    gclk[0] = 1'b0; step();
    pin_in = 1'b0; step();
    check("R8 latch holds while low", fb_out, 1'b1);

    mode = 3'd0; pin_in = 1'b1;
    apen = 1'b1; sel[U_AP] = 3'd0; sel[U_AR] = 3'd0;
    arsrc = 2'd2; #1ns;
    check("R10 reset wins over preset, no clock", fb_out, 1'b0);
    step();
    arsrc = 2'd0; #1ns;
    check("R10 preset without clock", fb_out, 1'b1);
    step();
    apen = 1'b0; arsrc = 2'd3; sel[U_AR] = 3'd7; gclr = 1'b1; #1ns;
    check("R10 global clear", fb_out, 1'b0);
    step();
    gclr = 1'b0; arsrc = 2'd0;

    oreg = 1'b0; route = '0; casc_in = 1'b0; xsrc = 2'd1; sel[U_FOLD] = 3'd0; #1ns;
    check("R3 constant one operand", pin_out, 1'b1);
    check("R1 empty term is true", fold_out, 1'b0);
    mt[0][0] = 1'b1; arr_in[0] = 1'b0; #1ns;
    check("R1 true-input term false", fold_out, 1'b1);
    xsrc = 2'd0; casc_in = 1'b1; #1ns;
    check("R2 cascade into sum", pin_out, 1'b1);
    oesrc = 3'd1; goe = 2'b00; #1ns;
    check("R12 inverted enable", pin_oe, 1'b1);
    step();

    for (int c = 0; c < 80; c++) begin
      rand_cfg();
      for (int n = 0; n < 25; n++) begin
        arr_in  = NI'($urandom);
        casc_in = ($urandom % 4 == 0);
        gclk    = 3'($urandom);
        gclr    = ($urandom % 6 == 0);
        goe     = 2'($urandom);
        pin_in  = 1'($urandom);
        step();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule